// File: doc/BRIEF.md
# Power-Mode Switch Request Sequencer

This block moves a processor core between its supported speed modes. A host
selects a mode by table index. The block looks up the 32-bit power-control
word for that index in a small table, which is loaded through a configuration
write port. It then drives a simple request/acknowledge register bus to the
power-management unit. First it makes three ordered writes to the control
register. After that it polls the 64-bit status register until the change is
confirmed or a poll budget runs out.

The host can also ask for a resynchronisation. In that case the block reads
the status register once and scans the table for the first entry whose speed
code matches the live speed. It reports that index and re-applies the entry,
which puts the hardware back into a consistent setting after reset or
firmware hand-over. The block keeps the current mode index and a valid flag
for it. It signals completion with a one-cycle pulse and raises a timeout flag
when confirmation never arrives.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timedOut`, `curValid` and `pmReq` are all 0.
- R2: A switch makes exactly three control-register writes (`pmSelStat`=0), in this order: `0x0000_0000`, then `0x8000_0000`, then `0x8000_0000` OR the table word. Bit 31 is the half-select bit, where 1 addresses the low half.
- R3: After the writes the block reads status (`pmSelStat`=1). A read confirms the change when status bit 61 (received) is 0 and status bits 57:56 equal bits 18:17 of the requested table word. Bits 19:17 are the speed code: 0 is full, 1 is half, 2 is quarter.
- R4: A status read with bit 60 (completed) set ends polling, whatever the speed bits hold.
- R5: At most `POLL_MAX` status reads are made per switch, and `WAIT_CYCLES` idle cycles separate successive reads. If all reads go unconfirmed, `timedOut` is set at `done`. The next accepted request clears it.
- R6: At `done`, `curIdx` takes the requested index and `curValid` is 1, even after a timeout.
- R7: `done` is a one-cycle pulse. `busy` is 1 from the cycle after acceptance through the `done` cycle. With a bus that acknowledges one cycle after each request, a switch confirmed on read k shows `done` at 9 + (k-1)·(2+`WAIT_CYCLES`) clock edges after the request edge, counting that edge.
- R8: Requests that arrive while `busy` is 1 are ignored. A switch request whose index is not below `NUM_MODES` is ignored.
- R9: A sync request (`reqSync`) reads status once and scans the table upward from index 0. The first entry whose bits 18:17 equal status bits 57:56 gives `qryIdx`, and that entry is then switched to as in R2 to R6.
- R10: If no entry matches, a sync sets `qryIdx` to `NUM_MODES`, makes no writes, leaves `curValid` at 0, and pulses `done` 3 edges after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Table entry write strobe |
| cfgIdx | input | IDX_W | Table entry index |
| cfgWord | input | 32 | Power-control word for that entry |
| reqSwitch | input | 1 | Switch request (one-cycle pulse) |
| reqIdx | input | IDX_W | Requested mode index |
| reqSync | input | 1 | Resynchronisation request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timedOut | output | 1 | Last switch ended without confirmation |
| curIdx | output | IDX_W | Current mode index |
| curValid | output | 1 | curIdx is meaningful |
| qryIdx | output | IDX_W | Result of the last status-to-index scan |
| pmReq | output | 1 | Bus request, held until acknowledged |
| pmWrite | output | 1 | 1 = write, 0 = read |
| pmSelStat | output | 1 | 0 = control register, 1 = status register |
| pmWdata | output | 32 | Control write data |
| pmAck | input | 1 | Bus acknowledge |
| pmRdata | input | 64 | Status read data, valid with pmAck |

## Verification
Each bus transfer takes two edges: the model acknowledges one cycle after it sees a request. A switch therefore reaches its first status answer 8 edges after acceptance, and each unconfirmed read adds the wait window plus one more transfer. The bench counts edges from the request edge to the cycle where `done` is seen and compares the count with that formula. A sync adds one extra transfer, and a sync that finds no match finishes after 3 edges. Outputs are sampled on the falling edge, so every registered update from the preceding rising edge is already visible. The write log and the status-read count are compared with the expected values once each operation ends.

// File: rtl/pms_pkg.sv
package pms_pkg;

  // Control word layout
  localparam int SEL_BIT      = 31;
  localparam int SPD_LO       = 17;
  // Status word layout
  localparam int ST_RCV_BIT   = 61;
  localparam int ST_CMP_BIT   = 60;
  localparam int ST_SPD_LO    = 56;

  // Which control write is on the bus
  typedef enum logic [1:0] {
    WR_ZERO   = 2'd0,
    WR_SELECT = 2'd1,
    WR_WORD   = 2'd2
  } wrKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    acceptSw;
    logic    acceptSync;
    logic    takeQuery;
    logic    pollInc;
    logic    waitLoad;
    logic    commit;
    logic    setTimeout;
    wrKind_e wSel;
  } pmsStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_QRD   = 3'd1,
    S_W0    = 3'd2,
    S_W1    = 3'd3,
    S_W2    = 3'd4,
    S_PRD   = 3'd5,
    S_PWAIT = 3'd6,
    S_FIN   = 3'd7
  } pmsState_e;

endpackage

// File: rtl/pms_datapath.sv
module pms_datapath
  import pms_pkg::*;
#(
  parameter int NUM_MODES   = 4,
  parameter int POLL_MAX    = 10,
  parameter int WAIT_CYCLES = 12500,
  parameter int IDX_W       = $clog2(NUM_MODES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [31:0]      cfgWord,
  input  logic [IDX_W-1:0] reqIdx,
  input  pmsStrobe_t       stb,
  input  logic [63:0]      pmRdata,
  output logic             reqIdxOk,
  output logic             statusOk,
  output logic             queryHit,
  output logic             pollLast,
  output logic             waitDone,
  output logic [31:0]      pmWdata,
  output logic [IDX_W-1:0] curIdx,
  output logic             curValid,
  output logic [IDX_W-1:0] qryIdx,
  output logic             timedOut
);

  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [IDX_W-1:0]  MODE_CNT   = IDX_W'(NUM_MODES);
  localparam logic [POLL_W-1:0] POLL_LASTV = POLL_W'(POLL_MAX - 1);
  localparam logic [WAIT_W-1:0] WAIT_INIT  = WAIT_W'(WAIT_CYCLES - 1);

  logic [31:0]       modeTab [NUM_MODES];
  logic [IDX_W-1:0]  tgtIdx;
  logic [31:0]       tgtWord;
  logic [POLL_W-1:0] pollCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [IDX_W-1:0]  scanIdx;
  logic [1:0]        liveSpd;

  // Mode table, one register per entry
  for (genvar gi = 0; gi < NUM_MODES; gi++) begin : g_tab
    always_ff @(posedge clk) begin
      if (!rstN)
        modeTab[gi] <= '0;
      else if (cfgWe && cfgIdx == IDX_W'(gi))
        modeTab[gi] <= cfgWord;
    end
  end

  assign reqIdxOk = (reqIdx < MODE_CNT);

  always_comb begin
    tgtWord = '0;
    for (int i = 0; i < NUM_MODES; i++)
      if (tgtIdx == IDX_W'(i)) tgtWord = modeTab[i];
  end

  assign liveSpd = pmRdata[ST_SPD_LO+1:ST_SPD_LO];

  // Confirmation tests on the status word
  assign statusOk = pmRdata[ST_CMP_BIT] ||
                    (!pmRdata[ST_RCV_BIT] && liveSpd == tgtWord[SPD_LO+1:SPD_LO]);

  // Upward scan: lowest matching index wins
  always_comb begin
    scanIdx  = MODE_CNT;
    queryHit = 1'b0;
    for (int i = 0; i < NUM_MODES; i++) begin
      if (!queryHit && modeTab[i][SPD_LO+1:SPD_LO] == liveSpd) begin
        queryHit = 1'b1;
        scanIdx  = IDX_W'(i);
      end
    end
  end

  logic unusedStatus;
  assign unusedStatus = ^{pmRdata[63:62], pmRdata[59:58], pmRdata[55:0]};

  always_comb begin
    unique case (stb.wSel)
      WR_ZERO:   pmWdata = 32'h0;
      WR_SELECT: pmWdata = 32'h1 << SEL_BIT;
      WR_WORD:   pmWdata = tgtWord | (32'h1 << SEL_BIT);
      default:   pmWdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtIdx <= '0;
      qryIdx <= '0;
    end else if (stb.acceptSw) begin
      tgtIdx <= reqIdx;
    end else if (stb.takeQuery) begin
      tgtIdx <= scanIdx;
      qryIdx <= scanIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      pollCnt <= '0;
    else if (stb.acceptSw || stb.acceptSync)
      pollCnt <= '0;
    else if (stb.pollInc)
      pollCnt <= pollCnt + 1'b1;
  end
  assign pollLast = (pollCnt == POLL_LASTV);

  always_ff @(posedge clk) begin
    if (!rstN)
      waitCnt <= '0;
    else if (stb.waitLoad)
      waitCnt <= WAIT_INIT;
    else if (waitCnt != '0)
      waitCnt <= waitCnt - 1'b1;
  end
  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx   <= '0;
      curValid <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      if (stb.acceptSync) curValid <= 1'b0;
      if (stb.acceptSw || stb.acceptSync) timedOut <= 1'b0;
      if (stb.setTimeout) timedOut <= 1'b1;
      if (stb.commit) begin
        curIdx   <= tgtIdx;
        curValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSwitch,
  input  logic       reqSync,
  input  logic       reqIdxOk,
  input  logic       pmAck,
  input  logic       statusOk,
  input  logic       queryHit,
  input  logic       pollLast,
  input  logic       waitDone,
  output pmsStrobe_t stb,
  output logic       busy,
  output logic       done,
  output logic       pmReq,
  output logic       pmWrite,
  output logic       pmSelStat
);

  pmsState_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    stb = '0;
    nxt = st;
    unique case (st)
      S_IDLE: begin
        if (reqSwitch && reqIdxOk) begin
          stb.acceptSw = 1'b1;
          nxt = S_W0;
        end else if (reqSync) begin
          stb.acceptSync = 1'b1;
          nxt = S_QRD;
        end
      end
      S_QRD: begin
        if (pmAck) begin
          stb.takeQuery = 1'b1;
          nxt = queryHit ? S_W0 : S_FIN;
        end
      end
      S_W0: begin
        stb.wSel = WR_ZERO;
        if (pmAck) nxt = S_W1;
      end
      S_W1: begin
        stb.wSel = WR_SELECT;
        if (pmAck) nxt = S_W2;
      end
      S_W2: begin
        stb.wSel = WR_WORD;
        if (pmAck) nxt = S_PRD;
      end
      S_PRD: begin
        if (pmAck) begin
          if (statusOk) begin
            stb.commit = 1'b1;
            nxt = S_FIN;
          end else if (pollLast) begin
            stb.commit     = 1'b1;
            stb.setTimeout = 1'b1;
            nxt = S_FIN;
          end else begin
            stb.pollInc  = 1'b1;
            stb.waitLoad = 1'b1;
            nxt = S_PWAIT;
          end
        end
      end
      S_PWAIT: begin
        if (waitDone) nxt = S_PRD;
      end
      S_FIN:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign pmReq     = (st == S_QRD) || (st == S_W0) || (st == S_W1) ||
                     (st == S_W2) || (st == S_PRD);
  assign pmWrite   = (st == S_W0) || (st == S_W1) || (st == S_W2);
  assign pmSelStat = (st == S_QRD) || (st == S_PRD);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int NUM_MODES   = 4,
  parameter int POLL_MAX    = 10,
  parameter int WAIT_CYCLES = 12500,
  localparam int IDX_W      = $clog2(NUM_MODES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [31:0]      cfgWord,
  input  logic             reqSwitch,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic             reqSync,
  output logic             busy,
  output logic             done,
  output logic             timedOut,
  output logic [IDX_W-1:0] curIdx,
  output logic             curValid,
  output logic [IDX_W-1:0] qryIdx,
  output logic             pmReq,
  output logic             pmWrite,
  output logic             pmSelStat,
  output logic [31:0]      pmWdata,
  input  logic             pmAck,
  input  logic [63:0]      pmRdata
);

  pmsStrobe_t stb;
  logic reqIdxOk, statusOk, queryHit, pollLast, waitDone;

  pms_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqSwitch(reqSwitch), .reqSync(reqSync), .reqIdxOk(reqIdxOk),
    .pmAck(pmAck), .statusOk(statusOk), .queryHit(queryHit),
    .pollLast(pollLast), .waitDone(waitDone),
    .stb(stb), .busy(busy), .done(done),
    .pmReq(pmReq), .pmWrite(pmWrite), .pmSelStat(pmSelStat)
  );

  pms_datapath #(
    .NUM_MODES(NUM_MODES), .POLL_MAX(POLL_MAX),
    .WAIT_CYCLES(WAIT_CYCLES), .IDX_W(IDX_W)
  ) i_dp (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgWord(cfgWord),
    .reqIdx(reqIdx), .stb(stb), .pmRdata(pmRdata),
    .reqIdxOk(reqIdxOk), .statusOk(statusOk), .queryHit(queryHit),
    .pollLast(pollLast), .waitDone(waitDone), .pmWdata(pmWdata),
    .curIdx(curIdx), .curValid(curValid), .qryIdx(qryIdx),
    .timedOut(timedOut)
  );

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int POLL_MAX = 10,
  parameter int IDX_W    = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic             timedOut,
  input logic [IDX_W-1:0] curIdx,
  input logic             pmReq,
  input logic             pmWrite,
  input logic             pmSelStat,
  input logic [31:0]      pmWdata,
  input logic             pmAck
);

  localparam int RD_LIMIT = POLL_MAX + 1;
  int rdCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) rdCnt <= 0;
    else if (pmReq && !pmWrite && pmAck) rdCnt <= rdCnt + 1;
  end

  AST_WRITE_TO_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    (pmReq && pmWrite) |-> !pmSelStat);                              // R2
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (pmReq && !pmAck) |=> (pmReq && $stable(pmWrite) && $stable(pmWdata))); // R2
  AST_READ_IS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (pmReq && !pmWrite) |-> pmSelStat);                              // R3
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    rdCnt <= RD_LIMIT);                                              // R5
  AST_TIMEOUT_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> done);                                       // R5
  AST_MODE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (curIdx != $past(curIdx)) |-> done);                             // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                                 // R7
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);                                                  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !pmReq);                                               // R8

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.POLL_MAX(POLL_MAX), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .timedOut(timedOut),
  .curIdx(curIdx), .pmReq(pmReq), .pmWrite(pmWrite), .pmSelStat(pmSelStat),
  .pmWdata(pmWdata), .pmAck(pmAck)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;

  localparam int NM    = 4;
  localparam int PMAX  = 10;
  localparam int WAITC = 5;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [IW-1:0] cfgIdx = '0;
  logic [31:0] cfgWord = '0;
  logic reqSwitch = 1'b0;
  logic [IW-1:0] reqIdx = '0;
  logic reqSync = 1'b0;
  logic busy, done, timedOut, curValid, pmReq, pmWrite, pmSelStat;
  logic [IW-1:0] curIdx, qryIdx;
  logic [31:0] pmWdata;
  logic pmAck = 1'b0;
  logic [63:0] pmRdata = '0;

  always #4 clk = ~clk;

  pwr_mode_seq #(.NUM_MODES(NM), .POLL_MAX(PMAX), .WAIT_CYCLES(WAITC)) i_pwr_mode_seq (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgWord(cfgWord),
    .reqSwitch(reqSwitch), .reqIdx(reqIdx), .reqSync(reqSync),
    .busy(busy), .done(done), .timedOut(timedOut), .curIdx(curIdx),
    .curValid(curValid), .qryIdx(qryIdx), .pmReq(pmReq), .pmWrite(pmWrite),
    .pmSelStat(pmSelStat), .pmWdata(pmWdata), .pmAck(pmAck), .pmRdata(pmRdata)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] tab [NM];
  logic [31:0] wrLog[$];
  logic [63:0] statQ[$];
  logic [63:0] statDefault = '0;
  int rdCount = 0;
  bit finished = 0;

  // Power-management unit model: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (pmReq && pmAck) begin
      if (pmWrite) wrLog.push_back(pmWdata);
      else rdCount <= rdCount + 1;
    end
    if (pmReq && !pmAck) begin
      pmAck <= 1'b1;
      if (!pmWrite) pmRdata <= (statQ.size() > 0) ? statQ.pop_front() : statDefault;
    end else begin
      pmAck <= 1'b0;
    end
  end

  function automatic logic [63:0] mkStat(bit rcv, bit cmp, logic [1:0] spd);
    logic [63:0] s = 64'h0;
    s[61] = rcv; s[60] = cmp; s[57:56] = spd;
    return s;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkWrites(string req, logic [31:0] word);
    check(wrLog.size() == 3, req, wrLog.size(), 3);
    if (wrLog.size() == 3) begin
      check(wrLog[0] == 32'h0, req, wrLog[0], 0);
      check(wrLog[1] == 32'h8000_0000, req, wrLog[1], 32'h8000_0000);
      check(wrLog[2] == (32'h8000_0000 | word), req, wrLog[2], 32'h8000_0000 | word);
    end
  endtask

  // Issue an operation, count edges to done, check the done pulse width
  task automatic runOp(bit isSync, logic [IW-1:0] idx, int expLat,
                       bit disturb, string req);
    int cnt = 0;
    wrLog.delete();
    rdCount = 0;
    reqSync = isSync; reqSwitch = !isSync; reqIdx = idx;
    @(posedge clk); cnt = 1;
    @(negedge clk);
    reqSync = 1'b0; reqSwitch = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    while (!done && cnt < 400) begin
      if (disturb && cnt == 4) begin
        reqSwitch = 1'b1; reqIdx = 2; reqSync = 1'b1;
      end else begin
        reqSwitch = 1'b0; reqSync = 1'b0;
      end
      @(posedge clk); cnt++;
      @(negedge clk);
    end
    reqSwitch = 1'b0; reqSync = 1'b0;
    check(cnt == expLat, req, cnt, expLat);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7 done one cycle", done, 0);
  endtask

  initial begin
    tab[0] = 32'h0001_8123;   // full speed
    tab[1] = 32'h0003_8045;   // half speed
    tab[2] = 32'h0005_8000;   // quarter speed
    tab[3] = 32'h0003_8abc;   // half speed again
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && timedOut == 0 && curValid == 0 && pmReq == 0,
          "R1 reset state", {busy, done, timedOut, curValid, pmReq}, 0);
    rstN = 1'b1;
    for (int i = 0; i < NM; i++) begin
      @(negedge clk);
      cfgWe = 1'b1; cfgIdx = IW'(i); cfgWord = tab[i];
    end
    @(negedge clk); cfgWe = 1'b0;

    // R9: sync, status half speed, first match is index 1
    statQ.push_back(mkStat(0, 0, 2'd1));
    statQ.push_back(mkStat(0, 0, 2'd1));
    runOp(1, 0, 11, 0, "R9 sync latency");
    check(qryIdx == 1, "R9 first match index", qryIdx, 1);
    check(curIdx == 1 && curValid, "R6 mode after sync", curIdx, 1);
    checkWrites("R2 sync writes", tab[1]);

    // R3: confirmed on third read
    statQ.push_back(mkStat(1, 0, 2'd0));
    statQ.push_back(mkStat(1, 0, 2'd0));
    statQ.push_back(mkStat(0, 0, 2'd0));
    runOp(0, 0, 9 + 2 * (2 + WAITC), 0, "R3 latency third read");
    check(rdCount == 3, "R3 read count", rdCount, 3);
    check(curIdx == 0 && timedOut == 0, "R6 mode 0", curIdx, 0);
    checkWrites("R2 switch writes", tab[0]);

    // R4: completed bit with mismatched speed ends at first read
    statQ.push_back(mkStat(1, 1, 2'd0));
    runOp(0, 2, 9, 0, "R4 completed exit latency");
    check(curIdx == 2 && timedOut == 0, "R4 mode 2 no timeout", curIdx, 2);

    // R5: never confirmed
    statDefault = mkStat(1, 0, 2'd3);
    runOp(0, 1, 9 + (PMAX - 1) * (2 + WAITC), 0, "R5 timeout latency");
    check(rdCount == PMAX, "R5 poll count", rdCount, PMAX);
    check(timedOut == 1, "R5 timeout flag", timedOut, 1);
    check(curIdx == 1 && curValid, "R6 mode after timeout", curIdx, 1);

    // R5: flag cleared by next switch
    statQ.push_back(mkStat(0, 0, 2'd0));
    runOp(0, 0, 9, 0, "R5 recovery latency");
    check(timedOut == 0, "R5 timeout cleared", timedOut, 0);

    // R8: requests during busy are ignored
    statQ.push_back(mkStat(0, 0, 2'd1));
    runOp(0, 3, 9, 1, "R8 latency with disturbance");
    check(curIdx == 3, "R8 mode unchanged by busy request", curIdx, 3);
    checkWrites("R8 writes unchanged", tab[3]);
    @(negedge clk);
    check(busy == 0, "R8 second op not started", busy, 0);

    // R8: out-of-range index ignored
    wrLog.delete();
    reqSwitch = 1'b1; reqIdx = 3'd4;
    @(negedge clk); reqSwitch = 1'b0;
    check(busy == 0, "R8 out-of-range ignored", busy, 0);
    repeat (4) @(negedge clk);
    check(wrLog.size() == 0 && curIdx == 3, "R8 no writes out-of-range", wrLog.size(), 0);

    // R10: sync with no matching entry
    statDefault = mkStat(0, 0, 2'd3);
    runOp(1, 0, 3, 0, "R10 sync miss latency");
    check(qryIdx == 3'd4, "R10 miss index", qryIdx, 4);
    check(curValid == 0, "R10 invalid mode", curValid, 0);
    check(wrLog.size() == 0, "R10 no writes", wrLog.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule